// File: doc/BRIEF.md
# Attribute Controller Palette Mapper

This block holds the attribute-stage register set of a planar colour display pipeline and turns each 4-bit plane value into an 8-bit index for the colour look-up DAC. A host reaches the registers through one shared write port. A phase bit sends each write either to the index register or to the register that the index selects. The phase flips on every write. A read of the display status port forces the phase back to index, which gives software a known starting point.

The register set has sixteen 6-bit palette entries, a mode word, a border colour, a plane-enable mask, a panning value and a colour-select word. The border colour and the panning value are only stored. On the pixel side, the incoming plane value is masked by the plane-enable bits and then looked up in the palette. The palette entry is then widened to 8 bits with colour-select bits. Two widening modes exist, and a mode bit chooses between them. The result is registered.

Top module: `attr_ctrl`

## Requirements
- R1: While the phase is 0, a write on `wr_stb` loads `wr_data[4:0]` into the index, which `idx_rdata` returns zero-extended. Every write toggles the phase, so the write that follows goes to the register selected by that index.
- R2: A pulse on `sts_rd` returns the phase to 0. If `sts_rd` and `wr_stb` are high in the same cycle, the write is handled under the phase it found, and the phase afterwards is 0.
- R3: Indices 0 to 15 select the palette entries. Each entry keeps only `wr_data[5:0]`, and reads of an entry return 0 in bits 7:6.
- R4: Index 16 is the mode word, and its bit 7 selects the palette widening mode. Index 17 is the border colour, index 18 the plane-enable mask (bits 3:0 are used), index 19 the panning value and index 20 the colour-select word. All five store and return the full 8 bits.
- R5: The plane value on `pix_in` is ANDed with plane-enable bits 3:0 before the palette lookup.
- R6: With mode bit 7 clear, `dac_idx[5:0]` is the full 6-bit palette entry.
- R7: With mode bit 7 set, `dac_idx[3:0]` is palette entry bits 3:0 and `dac_idx[5:4]` is colour-select bits 1:0. In both modes, `dac_idx[7:6]` is colour-select bits 3:2.
- R8: Indices 21 to 31 read back as 0. Writes to them change no register.
- R9: `dac_vld` follows `pix_vld` one cycle later. `dac_idx` is computed from the register values at the capture edge. While `pix_vld` is low, `dac_idx` holds its value.
- R10: After reset, the phase, the index, all registers and both pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Write data |
| sts_rd | input | 1 | Status-port read pulse; clears the phase |
| idx_rdata | output | 8 | Current index, zero-extended (index port read) |
| reg_rdata | output | 8 | Contents of the indexed register (data port read) |
| pix_vld | input | 1 | Plane value valid |
| pix_in | input | 4 | Plane value |
| dac_vld | output | 1 | DAC index valid, one cycle after `pix_vld` |
| dac_idx | output | 8 | DAC index |

## Verification
The bench uses the package defaults: sixteen palette entries, a 5-bit index and five extra registers. Because the 5-bit index space is larger than the 21 defined registers, random index writes regularly land on the unused range. Random plane values then reach every palette entry under many plane-enable masks. Directed cases cover a status read in the middle of a data phase, a status read in the same cycle as a write, and each widening mode with different colour-select values.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int REG_W     = 8;
  localparam int IDX_W     = 5;
  localparam int NUM_PAL   = 16;
  localparam int PAL_W     = 6;
  localparam int PAL_AW    = $clog2(NUM_PAL);
  localparam int PIX_W     = 4;
  localparam int DAC_W     = 8;
  localparam int NUM_MISC  = 5;
  localparam int MISC_BASE = NUM_PAL;
  localparam int MISC_AW   = $clog2(NUM_MISC);
  localparam int LAST_IDX  = MISC_BASE + NUM_MISC - 1;

  // slot order inside the extra-register bank
  localparam int SLOT_MODE   = 0;
  localparam int SLOT_BORDER = 1;
  localparam int SLOT_PLANE  = 2;
  localparam int SLOT_PAN    = 3;
  localparam int SLOT_CSEL   = 4;
  localparam int PSEL_BIT    = 7;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [PAL_W-1:0] pal_entry_t;
  typedef logic [NUM_PAL-1:0][PAL_W-1:0] pal_arr_t;
  typedef logic [NUM_MISC-1:0][REG_W-1:0] misc_arr_t;

  // widen a palette entry into a DAC index
  function automatic logic [DAC_W-1:0] attr_color_out(
    input pal_entry_t entry, input logic psel, input reg_t csel);
    logic [DAC_W-1:0] res;
    res[7:6] = csel[3:2];
    if (psel) res[5:0] = {csel[1:0], entry[3:0]};
    else      res[5:0] = entry;
    return res;
  endfunction
endpackage

// File: rtl/attr_index_ctrl.sv
module attr_index_ctrl
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sts_rd,
  output logic             phase,
  output logic [IDX_W-1:0] index,
  output logic             data_wr
);
  logic             phase_q;
  logic [IDX_W-1:0] index_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      index_q <= '0;
    end else begin
      if (wr_stb && !phase_q) index_q <= wr_data[IDX_W-1:0];
      if (sts_rd)      phase_q <= 1'b0;
      else if (wr_stb) phase_q <= ~phase_q;
    end
  end

  assign phase   = phase_q;
  assign index   = index_q;
  assign data_wr = wr_stb & phase_q;
endmodule

// File: rtl/attr_reg_file.sv
module attr_reg_file
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] index,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rdata,
  output pal_arr_t         pal,
  output reg_t             mode,
  output reg_t             plane_en,
  output reg_t             csel,
  output logic             known_hit
);
  pal_arr_t              pal_q;
  misc_arr_t             misc_q;
  logic [NUM_PAL-1:0]    pal_we;
  logic [NUM_MISC-1:0]   misc_we;
  logic [IDX_W-1:0]      misc_diff;
  logic [MISC_AW-1:0]    misc_off;

  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal_we
    assign pal_we[g] = data_wr && (index == IDX_W'(g));
  end
  for (genvar m = 0; m < NUM_MISC; m++) begin : g_misc_we
    assign misc_we[m] = data_wr && (index == IDX_W'(MISC_BASE + m));
  end

  assign known_hit = (index <= IDX_W'(LAST_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_q  <= '0;
      misc_q <= '0;
    end else begin
      for (int i = 0; i < NUM_PAL; i++)
        if (pal_we[i]) pal_q[i] <= wr_data[PAL_W-1:0];
      for (int j = 0; j < NUM_MISC; j++)
        if (misc_we[j]) misc_q[j] <= wr_data;
    end
  end

  assign misc_diff = index - IDX_W'(MISC_BASE);
  assign misc_off  = misc_diff[MISC_AW-1:0];

  always_comb begin
    rdata = '0;
    if (index < IDX_W'(NUM_PAL))
      rdata = REG_W'(pal_q[index[PAL_AW-1:0]]);
    else if (known_hit)
      rdata = misc_q[misc_off];
  end

  assign pal      = pal_q;
  assign mode     = misc_q[SLOT_MODE];
  assign plane_en = misc_q[SLOT_PLANE];
  assign csel     = misc_q[SLOT_CSEL];
endmodule

// File: rtl/attr_pix_path.sv
module attr_pix_path
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_in,
  input  pal_arr_t         pal,
  input  reg_t             mode,
  input  reg_t             plane_en,
  input  reg_t             csel,
  output logic             dac_vld,
  output logic [DAC_W-1:0] dac_idx
);
  logic [PIX_W-1:0] masked;
  pal_entry_t       entry;
  logic [DAC_W-1:0] dac_nxt;

  assign masked  = pix_in & plane_en[PIX_W-1:0];
  assign entry   = pal[masked];
  assign dac_nxt = attr_color_out(entry, mode[PSEL_BIT], csel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_vld <= 1'b0;
      dac_idx <= '0;
    end else begin
      dac_vld <= pix_vld;
      if (pix_vld) dac_idx <= dac_nxt;
    end
  end
endmodule

// File: rtl/attr_ctrl.sv
module attr_ctrl
  import attr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             sts_rd,
  output logic [REG_W-1:0] idx_rdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_in,
  output logic             dac_vld,
  output logic [DAC_W-1:0] dac_idx
);
  logic             phase_w;
  logic [IDX_W-1:0] cur_index;
  logic             data_wr;
  logic             known_hit;
  pal_arr_t         pal_w;
  reg_t             mode_w;
  reg_t             plane_w;
  reg_t             csel_w;

  attr_index_ctrl u_index (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .sts_rd(sts_rd), .phase(phase_w), .index(cur_index), .data_wr(data_wr)
  );

  attr_reg_file u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .index(cur_index),
    .wr_data(wr_data), .rdata(reg_rdata), .pal(pal_w), .mode(mode_w),
    .plane_en(plane_w), .csel(csel_w), .known_hit(known_hit)
  );

  attr_pix_path u_pix (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_in(pix_in),
    .pal(pal_w), .mode(mode_w), .plane_en(plane_w), .csel(csel_w),
    .dac_vld(dac_vld), .dac_idx(dac_idx)
  );

  assign idx_rdata = {{(REG_W-IDX_W){1'b0}}, cur_index};
endmodule

// File: rtl/attr_ctrl_chk.sv
module attr_ctrl_chk
  import attr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic [REG_W-1:0] wr_data,
  input logic             sts_rd,
  input logic             phase,
  input logic [IDX_W-1:0] index,
  input logic             known_hit,
  input logic [REG_W-1:0] reg_rdata,
  input logic             pix_vld,
  input logic             dac_vld,
  input logic [DAC_W-1:0] dac_idx,
  input reg_t             csel
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !sts_rd) |=> (phase != $past(phase))); // R1
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !phase) |=> (index == $past(wr_data[IDX_W-1:0]))); // R1
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd |=> !phase); // R2
  AST_PAL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (index < IDX_W'(NUM_PAL)) |-> (reg_rdata[REG_W-1:PAL_W] == '0)); // R3
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !known_hit |-> (reg_rdata == '0)); // R8
  AST_CSEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> (dac_idx[7:6] == $past(csel[3:2]))); // R7
  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |=> dac_vld); // R9
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> (!dac_vld && $stable(dac_idx))); // R9
endmodule

bind attr_ctrl attr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
  .sts_rd(sts_rd), .phase(phase_w), .index(cur_index), .known_hit(known_hit),
  .reg_rdata(reg_rdata), .pix_vld(pix_vld), .dac_vld(dac_vld),
  .dac_idx(dac_idx), .csel(csel_w)
);

// File: tb/test_attr_ctrl.sv
`timescale 1ns/1ps
module test_attr_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sts_rd = 1'b0;
  logic [7:0] idx_rdata;
  logic [7:0] reg_rdata;
  logic       pix_vld = 1'b0;
  logic [3:0] pix_in = 4'h0;
  logic       dac_vld;
  logic [7:0] dac_idx;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m_reg [32];
  logic [4:0] m_idx = 5'd0;
  logic       m_phase = 1'b0;
  logic [7:0] m_dac = 8'h00;

  always #2.5 clk = ~clk;

  attr_ctrl i_attr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .sts_rd(sts_rd), .idx_rdata(idx_rdata), .reg_rdata(reg_rdata),
    .pix_vld(pix_vld), .pix_in(pix_in), .dac_vld(dac_vld), .dac_idx(dac_idx)
  );

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // expected DAC index, written as arithmetic on the model registers
  function automatic logic [7:0] exp_dac(input logic [3:0] p);
    int masked, entry, cs, res;
    masked = int'(p) & (int'(m_reg[18]) % 16);
    entry  = int'(m_reg[masked]);
    cs     = int'(m_reg[20]);
    res    = ((cs / 4) % 4) * 64;
    if (m_reg[16] >= 8'h80) res += (cs % 4) * 16 + (entry % 16);
    else                    res += entry;
    return 8'(res);
  endfunction

  task automatic host_op(input logic w, input logic [7:0] d, input logic s);
    wr_stb = w; wr_data = d; sts_rd = s;
    @(negedge clk);
    wr_stb = 1'b0; sts_rd = 1'b0;
    if (w) begin
      if (!m_phase) m_idx = d[4:0];
      else if (m_idx < 5'd16) m_reg[m_idx] = d & 8'h3F;
      else if (m_idx <= 5'd20) m_reg[m_idx] = d;
    end
    if (s) m_phase = 1'b0;
    else if (w) m_phase = ~m_phase;
  endtask

  task automatic check_host(input string req);
    chk8({req, " index port"}, idx_rdata, {3'b000, m_idx});
    chk8({req, " data port"}, reg_rdata, m_reg[m_idx]);
  endtask

  task automatic put_reg(input logic [4:0] i, input logic [7:0] v);
    host_op(1'b0, 8'h00, 1'b1);
    host_op(1'b1, {3'b000, i}, 1'b0);
    host_op(1'b1, v, 1'b0);
  endtask

  task automatic select(input logic [4:0] i);
    host_op(1'b0, 8'h00, 1'b1);
    host_op(1'b1, {3'b000, i}, 1'b0);
  endtask

  task automatic pixel(input string req, input logic [3:0] p);
    logic [7:0] e;
    e = exp_dac(p);
    pix_vld = 1'b1; pix_in = p;
    @(negedge clk);
    pix_vld = 1'b0;
    m_dac = e;
    chk8({req, " dac_vld"}, {7'd0, dac_vld}, 8'h01);
    chk8({req, " dac_idx"}, dac_idx, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed_v;
    for (int i = 0; i < 32; i++) m_reg[i] = 8'h00;
    seed_v = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check_host("R10");
    chk8("R10 dac_vld", {7'd0, dac_vld}, 8'h00);
    chk8("R10 dac_idx", dac_idx, 8'h00);

    // R1: index masked to 5 bits
    host_op(1'b1, 8'hE4, 1'b0);
    check_host("R1");
    // R3: palette keeps 6 bits
    host_op(1'b1, 8'hFF, 1'b0);
    check_host("R3");
    select(5'd4);
    check_host("R3 readback");

    // R2: status read between index and data
    host_op(1'b0, 8'h00, 1'b1);
    host_op(1'b1, 8'h05, 1'b0);
    host_op(1'b0, 8'h00, 1'b1);
    host_op(1'b1, 8'h06, 1'b0);
    check_host("R2 mid-phase clear");
    // R2: status read coincident with an index write
    host_op(1'b0, 8'h00, 1'b1);
    host_op(1'b1, 8'h10, 1'b1);
    host_op(1'b1, 8'h11, 1'b0);
    check_host("R2 same-cycle");

    // R4: full-width extra registers
    for (int k = 16; k <= 20; k++) begin
      put_reg(5'(k), 8'(8'hA5 ^ (k * 8'h13)));
      check_host("R4");
    end

    // R8: unknown indices
    put_reg(5'd25, 8'hAA);
    check_host("R8 unknown read");
    put_reg(5'd31, 8'h55);
    for (int k = 0; k <= 20; k++) begin
      select(5'(k));
      check_host("R8 nothing changed");
    end

    // R5/R6/R7: directed pixel cases
    for (int k = 0; k < 16; k++) put_reg(5'(k), 8'(k * 8'h0B + 8'h07));
    put_reg(5'd18, 8'h0F);
    put_reg(5'd20, 8'h0E);
    put_reg(5'd16, 8'h00);
    pixel("R6", 4'hB);
    put_reg(5'd16, 8'h80);
    pixel("R7", 4'hB);
    put_reg(5'd20, 8'h05);
    pixel("R7 csel", 4'h3);
    put_reg(5'd18, 8'h00);
    pixel("R5 mask none", 4'hF);
    put_reg(5'd18, 8'h0A);
    pixel("R5 mask partial", 4'hF);
    // R9: hold while idle
    @(negedge clk);
    chk8("R9 idle vld", {7'd0, dac_vld}, 8'h00);
    chk8("R9 idle hold", dac_idx, m_dac);

    // mixed random traffic
    for (int it = 0; it < 600; it++) begin
      int act;
      act = int'($urandom % 5);
      if (act < 2) begin
        host_op(1'b1, 8'($urandom), 1'b0);
        check_host("R1 R4 R8 random");
      end else if (act == 2) begin
        host_op(($urandom % 2) == 1, 8'($urandom), 1'b1);
        check_host("R2 random");
      end else begin
        pixel("R5 R6 R7 R9 random", 4'($urandom));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule